// File: doc/BRIEF.md
# SPI Serial Flash Command Front-End

This block is the slave-side command engine of a small serial flash. It sits between a four-wire SPI bus (mode 0) and an abstract memory array. It frames every transaction with chip select and shifts in an opcode byte followed by address and data bytes. It then decides whether the command may touch the array. Reads are served byte by byte from a combinational array read port. Program and erase commands leave the block as single-cycle request strobes that carry an address.

Three guards protect the array. The first is a write-enable latch that must be armed before each modifying command. The second is a busy period, counted in system clocks, during which only the status query is answered. The third is a three-bit protect field in the status register that fences off an upper fraction of the address space. All SPI pins are oversampled in the system clock domain through synchronisers, so the SPI clock must be several times slower than the system clock.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: A transaction begins when chip select falls and ends when it rises. Bits are taken on the rising SPI clock edge, most significant bit first, and the first byte is the opcode.
- R2: Opcode 03h takes a 3-byte address. Every later byte slot returns the array byte at the current address, which then advances by one. The bits change after each falling SPI clock edge, MSB first, and chip select may rise after any bit.
- R3: Opcode 05h returns the status byte in every byte slot after the opcode. The byte is laid out as bit 0 busy, bit 1 write-enable latch, bits 4:2 protect field and bits 7:5 zero. It is answered even while busy.
- R4: Opcode 06h sets the write-enable latch and opcode 04h clears it.
- R5: The commands 06h, 04h, 01h, 02h, D8h and C7h act only if chip select rises after a whole number of bytes. Otherwise they have no effect at all, and the latch keeps its value.
- R6: Opcode 02h takes a 3-byte address followed by data bytes. It issues one program strobe carrying the address and the last complete data byte.
- R7: Opcode D8h with a 3-byte address issues a sector-erase strobe carrying that address. Opcode C7h issues a chip-erase strobe, with erase address 0, only when the protect field is 000.
- R8: The protect field guards part of the address space. 000 guards nothing, 001 the top eighth, 010 the top quarter, 011 the top half, and 1xx everything. A program or sector erase aimed at a guarded address issues no strobe.
- R9: A request is issued only when the latch was set. Any whole-byte 01h, 02h, D8h or C7h that is not ignored clears the latch, whether it is accepted or rejected.
- R10: Opcode 01h with the latch set loads the protect field from bits 4:2 of its first data byte, and the other bits are dropped. Without the latch it changes nothing.
- R11: An accepted request or status write keeps busy high for BUSY_CYCLES system clocks. While busy, every opcode except 05h is ignored: no read data, no latch change and no request.
- R12: The data output is 0 outside the read data phases, and at most one request strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data into the block |
| spi_miso | output | 1 | SPI data out of the block |
| mem_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data for mem_addr |
| prog_req | output | 1 | Single-cycle program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data byte |
| sector_erase_req | output | 1 | Single-cycle sector-erase request |
| chip_erase_req | output | 1 | Single-cycle chip-erase request |
| erase_addr | output | ADDR_W | Erase address (0 for chip erase) |

## Verification
The hardest state to reach is the busy window with a non-status command arriving inside it. The stimulus first completes an accepted program. Within the busy period it then sends a write enable, a status read and an array read, and checks that only the status read answers. A second awkward case is a program whose chip select rises mid-byte with the latch armed. The stimulus appends four stray bits to such a program, then reads the status to show that the latch is still set and that no strobe appeared. The protect field is swept through three settings, with addresses on each side of the guarded boundary.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SERA  = 8'hD8;
  localparam logic [7:0] OP_CERA  = 8'hC7;

  // top three address bits against the protect field
  function automatic logic fe_is_guarded(input logic [2:0] top, input logic [2:0] bp);
    logic [3:0] lim;
    if (bp[2]) return 1'b1;
    if (bp[1:0] == 2'd0) return 1'b0;
    lim = 4'd8 - (4'd1 << (bp[1:0] - 2'd1));
    return {1'b0, top} >= lim;
  endfunction

  function automatic logic [7:0] fe_status(input logic [2:0] bp, input logic wel, input logic busy);
    return {3'b000, bp, wel, busy};
  endfunction

  function automatic logic fe_is_modify(input logic [7:0] op);
    return op == OP_WRSR || op == OP_PROG || op == OP_SERA || op == OP_CERA;
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_busy.sv
module spi_fe_busy #(
  parameter int CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = cnt != '0;
endmodule

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              sector_erase_req,
  output logic              chip_erase_req,
  output logic [ADDR_W-1:0] erase_addr
);
  localparam int BC_W = 3;
  localparam logic [BC_W-1:0] BC_MAX = '1;

  // synchronised pins
  logic [2:0] pins_s;
  spi_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({spi_sck, spi_cs_n, spi_mosi}), .dout(pins_s));
  logic sck_s, cs_s, mosi_s;
  assign sck_s  = pins_s[2];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[0];

  logic sck_d, cs_d, active;
  logic [2:0] bit_cnt;
  logic [BC_W-1:0] byte_cnt;
  logic [6:0] rx_sh;
  logic [7:0] opcode, data_q, tx_sh;
  logic [ADDR_W-1:0] addr_q, rd_addr;
  logic ignore, wel, busy;
  logic [2:0] bp;

  // named events
  logic sck_rise_evt, sck_fall_evt, cs_start_evt, cs_end_evt, byte_done;
  logic [7:0] rx_byte;
  assign sck_rise_evt = active & sck_s & ~sck_d;
  assign sck_fall_evt = active & ~sck_s & sck_d;
  assign cs_start_evt = ~cs_s & cs_d;
  assign cs_end_evt   = active & cs_s & ~cs_d;
  assign byte_done    = sck_rise_evt && bit_cnt == 3'd7;
  assign rx_byte      = {rx_sh, mosi_s};

  // command execution at chip-select rise
  logic cmd_exec, addr_ok, do_prog, do_se, do_ce, do_wrsr, start_busy;
  assign cmd_exec  = cs_end_evt && bit_cnt == 3'd0 && !ignore && byte_cnt != '0;
  assign addr_ok   = !fe_is_guarded(addr_q[ADDR_W-1 -: 3], bp);
  assign do_prog   = cmd_exec && wel && opcode == OP_PROG && byte_cnt >= 3'd5 && addr_ok;
  assign do_se     = cmd_exec && wel && opcode == OP_SERA && byte_cnt >= 3'd4 && addr_ok;
  assign do_ce     = cmd_exec && wel && opcode == OP_CERA && bp == 3'b000;
  assign do_wrsr   = cmd_exec && wel && opcode == OP_WRSR && byte_cnt >= 3'd2;
  assign start_busy = do_prog | do_se | do_ce | do_wrsr;

  spi_fe_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy));

  // output phase
  logic rd_phase, is_read;
  assign is_read  = opcode == OP_READ;
  assign rd_phase = !ignore && ((is_read && byte_cnt >= 3'd4) ||
                                (opcode == OP_RDSR && byte_cnt >= 3'd1));
  assign mem_addr = rd_addr;

  logic data_slot;
  assign data_slot = (opcode == OP_WRSR) ? (byte_cnt == 3'd1) : (byte_cnt >= 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1; active <= 1'b0;
      bit_cnt <= '0; byte_cnt <= '0; rx_sh <= '0;
      opcode <= '0; data_q <= '0; tx_sh <= '0;
      addr_q <= '0; rd_addr <= '0; ignore <= 1'b0;
      spi_miso <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      if (cs_start_evt) begin
        active <= 1'b1; bit_cnt <= '0; byte_cnt <= '0; ignore <= 1'b0;
      end else if (cs_end_evt) begin
        active <= 1'b0; spi_miso <= 1'b0;
      end else begin
        if (sck_rise_evt) begin
          rx_sh   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          if (byte_cnt != BC_MAX) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0) begin
            opcode <= rx_byte;
            ignore <= busy && rx_byte != OP_RDSR;
          end else begin
            if (byte_cnt <= 3'd3) addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
            if (byte_cnt == 3'd3) rd_addr <= {addr_q[ADDR_W-9:0], rx_byte};
            if (data_slot) data_q <= rx_byte;
          end
        end
        if (sck_fall_evt && rd_phase) begin
          if (bit_cnt == 3'd0) begin
            if (is_read) begin
              spi_miso <= mem_rdata[7];
              tx_sh    <= {mem_rdata[6:0], 1'b0};
              rd_addr  <= rd_addr + 1'b1;
            end else begin
              spi_miso <= fe_status(bp, wel, busy) >> 7;
              tx_sh    <= {fe_status(bp, wel, busy) [6:0], 1'b0};
            end
          end else begin
            spi_miso <= tx_sh[7];
            tx_sh    <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // latch, protect field and request strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; bp <= '0;
      prog_req <= 1'b0; sector_erase_req <= 1'b0; chip_erase_req <= 1'b0;
      prog_addr <= '0; prog_data <= '0; erase_addr <= '0;
    end else begin
      if (cmd_exec) begin
        if (opcode == OP_WREN)            wel <= 1'b1;
        else if (opcode == OP_WRDI)       wel <= 1'b0;
        else if (fe_is_modify(opcode))    wel <= 1'b0;
      end
      if (do_wrsr) bp <= data_q[4:2];
      prog_req         <= do_prog;
      sector_erase_req <= do_se;
      chip_erase_req   <= do_ce;
      if (do_prog) begin
        prog_addr <= addr_q;
        prog_data <= data_q;
      end
      if (do_se)      erase_addr <= addr_q;
      else if (do_ce) erase_addr <= '0;
    end
  end
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_req,
  input logic              sector_erase_req,
  input logic              chip_erase_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              busy,
  input logic              wel,
  input logic [2:0]        bp,
  input logic              cs_end_evt,
  input logic              sck_fall_evt,
  input logic              spi_miso
);
  localparam longint FULL = longint'(1) << ADDR_W;

  function automatic logic in_guard(input logic [ADDR_W-1:0] a, input logic [2:0] f);
    longint base;
    if (f == 3'd0) return 1'b0;
    if (f >= 3'd4) return 1'b1;
    base = FULL - (FULL >> (4 - int'(f)));
    return longint'(a) >= base;
  endfunction

  logic any_req;
  assign any_req = prog_req | sector_erase_req | chip_erase_req;

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, sector_erase_req, chip_erase_req}));

  a_r11_req_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> busy);

  a_r11_no_req_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> !$past(busy));

  a_r9_req_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> ($past(wel) && !wel));

  a_r8_prog_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !in_guard(prog_addr, bp));

  a_r8_erase_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_req |-> !in_guard(erase_addr, bp));

  a_r7_chip_erase_open: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |-> bp == 3'b000);

  a_r4_latch_at_cs_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_end_evt));

  a_r2_miso_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> ($past(sck_fall_evt) || $past(cs_end_evt)));
endmodule

bind spi_flash_cmd_fe spi_fe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .prog_req(prog_req), .sector_erase_req(sector_erase_req), .chip_erase_req(chip_erase_req),
  .prog_addr(prog_addr), .erase_addr(erase_addr),
  .busy(busy), .wel(wel), .bp(bp),
  .cs_end_evt(cs_end_evt), .sck_fall_evt(sck_fall_evt), .spi_miso(spi_miso));

// File: tb/test_spi_flash_cmd_fe.sv
module test_spi_flash_cmd_fe;
  localparam int AW = 19;
  localparam int BUSY = 2000;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, prog_req, se_req, ce_req;
  logic [AW-1:0] mem_addr, prog_addr, erase_addr;
  logic [7:0] mem_rdata, prog_data;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b10101};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  spi_flash_cmd_fe #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) i_spi_flash_cmd_fe (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .sector_erase_req(se_req), .chip_erase_req(ce_req), .erase_addr(erase_addr));

  int n_chk = 0, n_fail = 0;
  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model state
  logic m_wel = 1'b0;
  logic [2:0] m_bp = 3'b000;
  int m_busy = 0;
  logic [36:0] exp_q[$];   // {kind[1:0], addr, data} kind 1 prog, 2 sector, 3 chip

  always @(negedge clk) if (m_busy > 0) m_busy--;

  always @(negedge clk) begin
    if (prog_req || se_req || ce_req) begin
      logic [36:0] got;
      got = prog_req ? {2'd1, prog_addr, prog_data} :
            se_req   ? {2'd2, erase_addr, 8'h00} : {2'd3, erase_addr, 8'h00};
      if (exp_q.size() == 0) check(1'b0, "R6/R7 unexpected strobe", longint'(got), 0);
      else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        check(got == e, "R6/R7 strobe content", longint'(got), longint'(e));
      end
    end
  end

  function automatic logic guarded(input logic [AW-1:0] a, input logic [2:0] f);
    case (f)
      3'd0: return 1'b0;
      3'd1: return a >= 19'h70000;
      3'd2: return a >= 19'h60000;
      3'd3: return a >= 19'h40000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_txn(input bq_t tx, input int extra, output bq_t ex, output int from,
                           output logic go_busy);
    int n;
    logic [7:0] op;
    logic ign, whole;
    logic [AW-1:0] a;
    n = tx.size(); op = tx[0]; ex = {}; from = n; go_busy = 1'b0;
    for (int k = 0; k < n; k++) ex.push_back(8'h00);
    ign = (m_busy > 0) && op != 8'h05;
    whole = extra == 0;
    a = (n >= 4) ? AW'({tx[1], tx[2], tx[3]}) : '0;
    if (op == 8'h03) begin
      from = 4;
      if (!ign) for (int k = 4; k < n; k++) ex[k] = mem_fn(a + AW'(k - 4));
    end
    if (op == 8'h05) begin
      from = 1;
      for (int k = 1; k < n; k++) ex[k] = {3'b000, m_bp, m_wel, m_busy > 0};
    end
    if (whole && !ign) begin
      case (op)
        8'h06: m_wel = 1'b1;
        8'h04: m_wel = 1'b0;
        8'h01: begin
          if (m_wel && n >= 2) begin m_bp = tx[1][4:2]; go_busy = 1'b1; end
          m_wel = 1'b0;
        end
        8'h02: begin
          if (m_wel && n >= 5 && !guarded(a, m_bp)) begin
            exp_q.push_back({2'd1, a, tx[n-1]}); go_busy = 1'b1;
          end
          m_wel = 1'b0;
        end
        8'hD8: begin
          if (m_wel && n >= 4 && !guarded(a, m_bp)) begin
            exp_q.push_back({2'd2, a, 8'h00}); go_busy = 1'b1;
          end
          m_wel = 1'b0;
        end
        8'hC7: begin
          if (m_wel && m_bp == 3'b000) begin
            exp_q.push_back({2'd3, {AW{1'b0}}, 8'h00}); go_busy = 1'b1;
          end
          m_wel = 1'b0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    @(negedge clk); sck = 1'b0; mosi = b;
    repeat (8) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic spi_xfer(input bq_t tx, input int extra, output bq_t rx);
    logic r;
    logic [7:0] v;
    rx = {};
    @(negedge clk); cs_n = 1'b0;
    repeat (16) @(negedge clk);
    foreach (tx[i]) begin
      v = '0;
      for (int b = 7; b >= 0; b--) begin
        spi_bit(tx[i][b], r);
        v = {v[6:0], r};
      end
      rx.push_back(v);
    end
    for (int k = 0; k < extra; k++) spi_bit(1'b0, r);
    @(negedge clk); sck = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic run(input bq_t tx, input int extra, input string req);
    bq_t rx, ex;
    int from;
    logic gb;
    model_txn(tx, extra, ex, from, gb);
    spi_xfer(tx, extra, rx);
    if (gb) m_busy = BUSY;
    for (int k = from; k < rx.size(); k++) check(rx[k] == ex[k], req, rx[k], ex[k]);
    check(exp_q.size() == 0, {req, " pending strobe"}, exp_q.size(), 0);
  endtask

  task automatic wait_idle();
    repeat (BUSY + 60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired (all requirements)", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check(miso == 1'b0 && !prog_req && !se_req && !ce_req, "R12 reset outputs",
          {miso, prog_req, se_req, ce_req}, 0);
    run('{8'h05, 8'h00}, 0, "R3 R1 status after reset");
    run('{8'h06}, 0, "R4 write enable");
    run('{8'h05, 8'h00, 8'h00}, 0, "R4 status latch set");
    run('{8'h04}, 0, "R4 write disable");
    run('{8'h05, 8'h00}, 0, "R4 status latch clear");
    run('{8'h03, 8'h00, 8'h12, 8'h30, 8'h00, 8'h00, 8'h00}, 0, "R2 R1 array read");
    run('{8'h03, 8'h07, 8'hFF, 8'hFE, 8'h00, 8'h00}, 0, "R2 read across byte carry");
    run('{8'h03, 8'h01, 8'h00, 8'hFF, 8'h00}, 3, "R2 read ended mid-bit");
    run('{8'h05, 8'h00}, 0, "R2 status after cut read");
    // R6 program, then busy window R11
    run('{8'h06}, 0, "R6 arm");
    run('{8'h02, 8'h01, 8'h23, 8'h45, 8'h11, 8'hA7}, 0, "R6 program");
    run('{8'h05, 8'h00}, 0, "R11 R9 busy status");
    run('{8'h06}, 0, "R11 write enable while busy");
    run('{8'h05, 8'h00}, 0, "R11 latch untouched while busy");
    run('{8'h03, 8'h00, 8'h00, 8'h40, 8'h00}, 0, "R11 R12 read ignored while busy");
    wait_idle();
    // R10 status write, only bits 4:2 kept
    run('{8'h06}, 0, "R10 arm");
    run('{8'h01, 8'hE4}, 0, "R10 status write");
    wait_idle();
    run('{8'h05, 8'h00}, 0, "R10 field loaded");
    // R8 guarded top eighth
    run('{8'h06}, 0, "R8 arm");
    run('{8'hD8, 8'h07, 8'h00, 8'h00}, 0, "R8 guarded sector erase");
    run('{8'h05, 8'h00}, 0, "R9 latch cleared on reject");
    run('{8'h06}, 0, "R7 arm");
    run('{8'hD8, 8'h06, 8'h80, 8'h00}, 0, "R7 R8 open sector erase");
    wait_idle();
    run('{8'h06}, 0, "R7 arm chip");
    run('{8'hC7}, 0, "R7 chip erase refused by field");
    // R5 partial byte program aborted
    run('{8'h06}, 0, "R5 arm");
    run('{8'h02, 8'h00, 8'h00, 8'h10, 8'h55}, 4, "R5 cut program");
    run('{8'h05, 8'h00}, 0, "R5 latch kept after cut");
    run('{8'h01, 8'h08}, 0, "R10 field to quarter");
    wait_idle();
    run('{8'h06}, 0, "R8 arm quarter");
    run('{8'h02, 8'h06, 8'h00, 8'h00, 8'h99}, 0, "R8 guarded program");
    run('{8'h01, 8'h00}, 0, "R10 write without latch");
    run('{8'h05, 8'h00}, 0, "R10 field unchanged");
    run('{8'h06}, 0, "R7 arm open");
    run('{8'h01, 8'h00}, 0, "R7 clear field");
    wait_idle();
    run('{8'h06}, 0, "R7 arm chip 2");
    run('{8'hC7}, 0, "R7 chip erase");
    wait_idle();
    run('{8'h06}, 0, "R8 arm all");
    run('{8'h01, 8'h10}, 0, "R8 field all");
    wait_idle();
    run('{8'h06}, 0, "R8 arm low");
    run('{8'h02, 8'h00, 8'h00, 8'h10, 8'h3C}, 0, "R8 whole array guarded");
    run('{8'h05, 8'h00, 8'h00}, 0, "R3 final status");
    check(miso == 1'b0, "R12 idle output", miso, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule